// File: doc/BRIEF.md
# Masked BCD Alarm Comparator

This block holds the alarm settings of a real-time clock and decides when the running calendar reaches them. Six byte-wide alarm registers cover seconds, minutes, hours, weekday, day of month and month. Each register holds a BCD value in its low seven bits and a per-field enable in bit 7. Any subset of the fields can therefore be left out of the match and act as "don't care". The calendar counters come in from the timekeeping core, and a one-cycle strobe marks each seconds update. On that strobe the block compares every enabled field with its counter. When all enabled fields agree, it sets a sticky alarm flag.

Software reaches the block over a simple byte register bus with a 4-bit index. The same bus gives access to a small control register that holds the alarm flag and the alarm interrupt enable. The interrupt output is registered and equals the flag gated by the enable. Software clears the flag by writing 0 to its bit. If the hardware sets the flag in the same cycle, the set wins, so an alarm is never lost to a late clear.

Top module: `bcd_alarm_cmp`

## Requirements
- R1: After reset, all six alarm registers, the alarm flag, the interrupt enable and `alarm_irq` are 0, and every register index reads 0.
- R2: The alarm registers sit at indices 8 through 13, ordered seconds, minutes, hours, weekday, day of month, month. A write to one of them stores all 8 bits, and reading the same index returns them one cycle after the address is presented.
- R3: A field takes part in the match only when bit 7 of its alarm register is 1. Its bits 6:0 must then equal the 7-bit counter input for that field. A field with bit 7 at 0 matches any counter value. The month field uses the same 1-to-12 BCD code as the month counter.
- R4: When no field has its enable bit set, the alarm flag is never set, whatever the counter values.
- R5: The match is evaluated only in a cycle where `sec_tick` is 1. A match present without the strobe does not set the flag. A match present with the strobe sets the flag at that clock edge.
- R6: The control register sits at index 14. Bit 0 is the alarm flag and bit 3 is the alarm interrupt enable; its other bits read 0. Writing bit 0 as 0 clears the flag. Writing bit 0 as 1 leaves the flag unchanged. Bit 3 takes the written value.
- R7: `alarm_irq` equals alarm flag AND interrupt enable. It is updated at the same clock edge as the flag and the enable.
- R8: If a strobe with a full match and a control write that clears the flag fall in the same cycle, the flag is left set.
- R9: Writes to indices 0 to 7 and 15 have no effect on any state, and those indices read 0.
- R10: Once set, the alarm flag stays set across later strobes, matching or not, until software clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register index for write and read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data of the index presented in the previous cycle |
| sec_tick | input | 1 | One-cycle strobe marking a seconds update of the calendar |
| cnt_sec | input | 7 | Seconds counter, BCD |
| cnt_min | input | 7 | Minutes counter, BCD |
| cnt_hour | input | 7 | Hours counter, BCD |
| cnt_wday | input | 7 | Weekday counter, BCD |
| cnt_mday | input | 7 | Day-of-month counter, BCD |
| cnt_mon | input | 7 | Month counter, BCD 1 to 12 |
| alarm_irq | output | 1 | Alarm interrupt, flag AND enable, registered |

## Verification
The bench goes after the empty mask. A design that treats "all fields don't care" as a match would raise the flag on every strobe. It drives a full match without the strobe, which catches a comparator that sets the flag continuously. It also fires a clearing write in the very cycle of a matching strobe. A design that gives the clear priority would lose that alarm. Random masks and counter values, with many counters copied from the alarm settings, check that only enabled fields count and that the flag stays sticky. Unmapped-index writes and writing 1 to the flag bit are checked at the read port, to catch a decoder or write path that reaches state it should not.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int DATA_W   = 8;
  localparam int CNT_W    = 7;
  localparam int ADDR_W   = 4;
  localparam int NUM_FLD  = 6;
  localparam int FLD_BASE = 8;
  localparam int CTRL_IDX = 14;
  localparam int EN_BIT   = 7;
  localparam int FLAG_BIT = 0;
  localparam int AIE_BIT  = 3;

  typedef enum logic [2:0] {
    F_SEC  = 3'd0,
    F_MIN  = 3'd1,
    F_HOUR = 3'd2,
    F_WDAY = 3'd3,
    F_MDAY = 3'd4,
    F_MON  = 3'd5
  } field_e;
endpackage

// File: rtl/alarm_field.sv
module alarm_field
  import alarm_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic [CW-1:0] cnt,
  output logic [DW-1:0] reg_q,
  output logic          en,
  output logic          hit
);
  always_ff @(posedge clk) begin
    if (rst) reg_q <= '0;
    else if (wr) reg_q <= wdata;
  end

  assign en  = reg_q[EN_BIT];
  // a disabled field never blocks the match
  assign hit = !en || (reg_q[CW-1:0] == cnt);
endmodule

// File: rtl/alarm_ctrl.sv
module alarm_ctrl
  import alarm_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctrl_wr,
  input  logic [DW-1:0] wdata,
  input  logic          tick,
  input  logic          match,
  output logic          flag_q,
  output logic          aie_q,
  output logic          irq_q
);
  logic flag_d, aie_d;

  always_comb begin
    flag_d = flag_q;
    if (ctrl_wr && !wdata[FLAG_BIT]) flag_d = 1'b0;
    // hardware set overrides a clear in the same cycle
    if (tick && match) flag_d = 1'b1;
    aie_d = ctrl_wr ? wdata[AIE_BIT] : aie_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      aie_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      aie_q  <= aie_d;
      irq_q  <= flag_d && aie_d;
    end
  end
endmodule

// File: rtl/bcd_alarm_cmp.sv
module bcd_alarm_cmp
  import alarm_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CNT_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          sec_tick,
  input  logic [CW-1:0] cnt_sec,
  input  logic [CW-1:0] cnt_min,
  input  logic [CW-1:0] cnt_hour,
  input  logic [CW-1:0] cnt_wday,
  input  logic [CW-1:0] cnt_mday,
  input  logic [CW-1:0] cnt_mon,
  output logic          alarm_irq
);
  localparam int NF = NUM_FLD;

  logic [CW-1:0] cnt_arr [NF];
  logic [DW-1:0] fld_q   [NF];
  logic [NF-1:0] en_vec, hit_vec;
  logic          any_en, all_hit, match;
  logic          ctrl_wr;
  logic          flag_q, aie_q;
  logic [DW-1:0] rd_mux;

  assign cnt_arr[F_SEC]  = cnt_sec;
  assign cnt_arr[F_MIN]  = cnt_min;
  assign cnt_arr[F_HOUR] = cnt_hour;
  assign cnt_arr[F_WDAY] = cnt_wday;
  assign cnt_arr[F_MDAY] = cnt_mday;
  assign cnt_arr[F_MON]  = cnt_mon;

  for (genvar i = 0; i < NF; i++) begin : g_fld
    logic fld_wr;
    assign fld_wr = wr_en && (addr == AW'(FLD_BASE + i));
    alarm_field #(.DW(DW), .CW(CW)) u_fld (
      .clk   (clk),
      .rst   (rst),
      .wr    (fld_wr),
      .wdata (wdata),
      .cnt   (cnt_arr[i]),
      .reg_q (fld_q[i]),
      .en    (en_vec[i]),
      .hit   (hit_vec[i])
    );
  end

  assign any_en  = |en_vec;
  assign all_hit = &hit_vec;
  assign match   = any_en && all_hit;
  assign ctrl_wr = wr_en && (addr == AW'(CTRL_IDX));

  alarm_ctrl #(.DW(DW)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .ctrl_wr (ctrl_wr),
    .wdata   (wdata),
    .tick    (sec_tick),
    .match   (match),
    .flag_q  (flag_q),
    .aie_q   (aie_q),
    .irq_q   (alarm_irq)
  );

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NF; i++)
      if (addr == AW'(FLD_BASE + i)) rd_mux = fld_q[i];
    if (addr == AW'(CTRL_IDX)) begin
      rd_mux[FLAG_BIT] = flag_q;
      rd_mux[AIE_BIT]  = aie_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else rdata <= rd_mux;
  end
endmodule

// File: rtl/bcd_alarm_chk.sv
module bcd_alarm_chk
  import alarm_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              sec_tick,
  input logic              alarm_irq,
  input logic              flag_q,
  input logic              aie_q,
  input logic              any_en,
  input logic              all_hit
);
  // R5
  flag_set_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(sec_tick));

  // R4
  empty_mask_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && !any_en && !flag_q) |=> !flag_q);

  // R8
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && any_en && all_hit) |=> flag_q);

  // R6
  clear_by_write_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_q) |-> $past(wr_en && addr == ADDR_W'(CTRL_IDX) && !wdata[FLAG_BIT]));

  // R7
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    alarm_irq |-> (aie_q && flag_q));

  // R7
  irq_when_armed_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q && aie_q) |-> alarm_irq);
endmodule

bind bcd_alarm_cmp bcd_alarm_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .addr      (addr),
  .wdata     (wdata),
  .sec_tick  (sec_tick),
  .alarm_irq (alarm_irq),
  .flag_q    (flag_q),
  .aie_q     (aie_q),
  .any_en    (any_en),
  .all_hit   (all_hit)
);

// File: tb/bcd_alarm_cmp_tb.sv
module bcd_alarm_cmp_tb;
  logic       clk = 0;
  logic       rst = 1;
  logic       wr_en = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic       sec_tick = 0;
  logic [6:0] cnt [6];
  logic       alarm_irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] m_alm [6];
  bit m_flag, m_aie;

  always #10 clk = ~clk;

  bcd_alarm_cmp u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .sec_tick(sec_tick),
    .cnt_sec(cnt[0]), .cnt_min(cnt[1]), .cnt_hour(cnt[2]),
    .cnt_wday(cnt[3]), .cnt_mday(cnt[4]), .cnt_mon(cnt[5]),
    .alarm_irq(alarm_irq)
  );

  function automatic bit exp_match();
    bit any = 0, all = 1;
    for (int i = 0; i < 6; i++)
      if (m_alm[i][7]) begin
        any = 1;
        if (m_alm[i][6:0] != cnt[i]) all = 0;
      end
    return any && all;
  endfunction

  function automatic logic [7:0] exp_ctrl();
    return {4'b0, m_aie, 2'b0, m_flag};
  endfunction

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
    if (a >= 8 && a <= 13) m_alm[a-8] = d;
    if (a == 14) begin
      m_aie = d[3];
      if (!d[0]) m_flag = 0;
    end
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  // strobe, optionally together with a control write
  task automatic tick(bit with_wr, logic [7:0] d);
    @(negedge clk);
    sec_tick = 1;
    if (with_wr) begin wr_en = 1; addr = 4'd14; wdata = d; end
    @(negedge clk);
    sec_tick = 0; wr_en = 0;
    if (with_wr) begin
      m_aie = d[3];
      if (!d[0]) m_flag = 0;
    end
    if (exp_match()) m_flag = 1;
  endtask

  task automatic set_cnt(logic [6:0] s, logic [6:0] mi, logic [6:0] h,
                         logic [6:0] w, logic [6:0] dd, logic [6:0] mo);
    cnt[0] = s; cnt[1] = mi; cnt[2] = h; cnt[3] = w; cnt[4] = dd; cnt[5] = mo;
  endtask

  initial begin
    logic [7:0] r;
    void'($urandom(32'd1234));
    for (int i = 0; i < 6; i++) begin m_alm[i] = 0; cnt[i] = 0; end
    m_flag = 0; m_aie = 0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    check("R1 irq", {7'b0, alarm_irq}, 8'h00);
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), r);
      check("R1 reset read", r, 8'h00);
    end

    // R2 register placement and readback
    for (int i = 0; i < 6; i++) wr(4'(8 + i), 8'(8'h11 * (i + 1)));
    for (int i = 0; i < 6; i++) begin
      rd(4'(8 + i), r);
      check("R2 readback", r, 8'(8'h11 * (i + 1)));
    end

    // R4 empty mask never fires, even with counters equal to the values
    for (int i = 0; i < 6; i++) wr(4'(8 + i), 8'h00);
    set_cnt(0, 0, 0, 0, 0, 0);
    tick(0, 0);
    rd(4'd14, r);
    check("R4 empty mask", r, 8'h00);

    // R3 only minutes enabled; others don't care
    wr(4'd9, 8'hB0);
    set_cnt(7'h12, 7'h30, 7'h05, 7'h03, 7'h21, 7'h11);
    // R5 a match without the strobe does nothing
    repeat (3) @(negedge clk);
    rd(4'd14, r);
    check("R5 no strobe", r, 8'h00);
    tick(0, 0);
    rd(4'd14, r);
    check("R3 minutes match", r, exp_ctrl());
    check("R7 irq gated off", {7'b0, alarm_irq}, 8'h00);
    wr(4'd14, 8'h09);
    check("R7 irq raised", {7'b0, alarm_irq}, 8'h01);

    // R10 sticky across a non-matching strobe
    cnt[1] = 7'h31;
    tick(0, 0);
    rd(4'd14, r);
    check("R10 sticky", r, 8'h09);

    // R6 clear, then writing 1 to flag does not set it
    wr(4'd14, 8'h08);
    rd(4'd14, r);
    check("R6 clear", r, 8'h08);
    check("R7 irq dropped", {7'b0, alarm_irq}, 8'h00);
    wr(4'd14, 8'hFF);
    rd(4'd14, r);
    check("R6 write one", r, 8'h08);

    // R3 month field uses counter code, mismatch in other enabled field blocks
    wr(4'd13, 8'h92);
    set_cnt(7'h00, 7'h30, 7'h00, 7'h00, 7'h00, 7'h11);
    tick(0, 0);
    rd(4'd14, r);
    check("R3 month mismatch", r, 8'h08);
    cnt[5] = 7'h12;
    // R8 clear write in the same cycle as a matching strobe
    tick(1, 8'h08);
    rd(4'd14, r);
    check("R8 set wins", r, 8'h09);
    check("R8 irq", {7'b0, alarm_irq}, 8'h01);

    // R9 unmapped writes
    wr(4'd15, 8'hFF);
    wr(4'd3, 8'hFF);
    rd(4'd15, r);
    check("R9 idx15 read", r, 8'h00);
    rd(4'd3, r);
    check("R9 idx3 read", r, 8'h00);
    rd(4'd14, r);
    check("R9 ctrl kept", r, 8'h09);
    rd(4'd13, r);
    check("R9 month kept", r, 8'h92);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 9);
      if (op < 3) begin
        int f = $urandom_range(0, 5);
        wr(4'(8 + f), {($urandom_range(0, 2) == 0) ? 1'b1 : 1'b0, 7'($urandom_range(0, 127))});
      end else if (op < 8) begin
        for (int i = 0; i < 6; i++)
          cnt[i] = ($urandom_range(0, 3) != 0) ? m_alm[i][6:0] : 7'($urandom_range(0, 127));
        tick(0, 0);
        check("R3 random irq", {7'b0, alarm_irq}, {7'b0, m_flag & m_aie});
      end else if (op == 8) begin
        wr(4'd14, {4'b0, 1'($urandom_range(0, 1)), 2'b0, 1'($urandom_range(0, 1))});
        check("R7 random irq", {7'b0, alarm_irq}, {7'b0, m_flag & m_aie});
      end else begin
        rd(4'd14, r);
        check("R6 random ctrl", r, exp_ctrl());
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule